// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Misprediction Recovery

This block predicts control flow at instruction fetch and repairs wrong guesses when branches resolve. Each cycle the fetch address is looked up in a small direct-mapped table. A hit says the instruction is expected to be a branch and supplies a stored target, a direction and a conditional/unconditional type. The block also produces the next fetch address: the stored target when the hit predicts taken, and the sequential address (fetch address + 4) otherwise. A miss is treated as an implicit not-taken prediction.

Later in the pipe a branch resolves. The pipe hands back the branch address, its real outcome and target, its type, and the prediction that travelled with it. The block compares the real outcome with that prediction. A wrong direction or a wrong taken target raises a flush together with the correct restart address. In the same cycle the table is trained. An existing entry has its history counter stepped, and its target is refreshed if the branch was taken. A branch that misses the table gets an entry only if it was taken.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset invalidates every entry, so every lookup after reset misses.
- R2: On a miss, fetchHit and fetchTaken are 0 and nextPc equals fetchPc + 4.
- R3: A lookup hits only when the entry selected by fetchPc[5:2] is valid and its stored tag equals fetchPc[31:6]. An entry with the same index but a different tag misses.
- R4: A resolved taken branch that misses the table allocates an entry with counter value 2, so its next lookup hits and predicts taken. A resolved not-taken branch that misses allocates nothing.
- R5: Each entry's direction history is a 2-bit counter. It counts up on taken and down on not-taken, saturates at 0 and 3, and predicts taken when its value is 2 or 3.
- R6: A hit on an entry whose type is unconditional (fetchUncond = 1) predicts taken whatever the counter holds.
- R7: If the prediction was not-taken and the branch resolves taken, flush is 1 and redirectPc equals resTarget in that same cycle.
- R8: If the prediction was taken and the branch resolves not-taken, flush is 1 and redirectPc equals resPc + 4 in that same cycle.
- R9: If the prediction and the outcome are both taken but predTarget differs from resTarget, flush is 1 and redirectPc equals resTarget.
- R10: A correct prediction leaves flush at 0, and flush is never 1 without resValid.
- R11: When a lookup and an update address the same entry in one cycle, the lookup sees the contents from before the update. The update is visible from the next cycle.
- R12: An allocation whose index matches a valid entry with a different tag replaces that entry, and the old branch then misses.
- R13: A taken resolution writes resTarget into the hit entry. A not-taken resolution leaves the stored target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchPc | input | 32 | Address being fetched this cycle |
| fetchHit | output | 1 | Lookup found a matching valid entry |
| fetchTaken | output | 1 | Predicted direction is taken |
| fetchUncond | output | 1 | Type of the hit entry, 1 = unconditional |
| fetchTarget | output | 32 | Stored target of the hit entry |
| nextPc | output | 32 | Chosen next fetch address |
| resValid | input | 1 | A branch resolves this cycle |
| resPc | input | 32 | Address of the resolving branch |
| resTaken | input | 1 | Real outcome, 1 = taken |
| resTarget | input | 32 | Real taken target |
| resUncond | input | 1 | Branch type, 1 = unconditional |
| predTaken | input | 1 | Direction that was predicted for this branch at fetch |
| predTarget | input | 32 | Target that was predicted for this branch at fetch |
| flush | output | 1 | Misprediction: squash younger instructions |
| redirectPc | output | 32 | Correct restart address while flush is 1 |

## Verification
The bench drives the counter to both ends and then reads the prediction back. A counter that wraps instead of saturating would predict taken after repeated not-taken outcomes, or not-taken after repeated taken ones. It trains one branch and then resolves a second branch with the same index but a different tag. A table that compares only the index would hit for the wrong branch, and one that does not replace entries would keep predicting the old branch. It lookups an entry in the same cycle as that entry's update, which exposes a write-through read. It checks that a wrong taken target, and not only a wrong direction, raises the flush. It also checks that a not-taken resolution keeps the stored target and that an unconditional entry predicts taken even when its counter reads weak not-taken.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] ctr_t;

  // counter value given to a freshly allocated entry (weakly taken)
  localparam ctr_t CTR_INIT = 2'd2;

  // strobes from the control to the table datapath
  typedef struct packed {
    logic wrEn;        // write the entry addressed by the resolving branch
    logic loadTarget;  // replace the stored target with the resolved one
    ctr_t ctrNext;     // history value to store
  } btbStrobe_t;

  function automatic ctr_t ctrStep(input ctr_t cur, input logic taken);
    if (taken) return (cur == 2'd3) ? 2'd3 : cur + 2'd1;
    else       return (cur == 2'd0) ? 2'd0 : cur - 2'd1;
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        lkIdx,
  input  logic [PC_W-IDX_W-3:0]   lkTag,
  output logic                    lkHit,
  output logic                    lkTaken,
  output logic                    lkUncond,
  output logic [PC_W-1:0]         lkTarget,
  input  logic [IDX_W-1:0]        upIdx,
  input  logic [PC_W-IDX_W-3:0]   upTag,
  input  logic [PC_W-1:0]         upTarget,
  input  logic                    upUncond,
  output logic                    upHit,
  output ctr_t                    upCtr,
  input  btbStrobe_t              stb
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - 2;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ    [ENTRIES];
  logic [PC_W-1:0]    targetQ [ENTRIES];
  ctr_t               ctrQ    [ENTRIES];
  logic [ENTRIES-1:0] uncondQ;
  logic [ENTRIES-1:0] wrSel;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
    assign wrSel[e] = stb.wrEn && (upIdx == IDX_W'(e));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wrSel[e]) begin
          validQ[e]  <= 1'b1;
          tagQ[e]    <= upTag;
          ctrQ[e]    <= stb.ctrNext;
          uncondQ[e] <= upUncond;
          if (stb.loadTarget) targetQ[e] <= upTarget;
        end
      end
    end
  end

  // reads see the registered contents, so a same-cycle update is not visible
  assign lkHit    = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
  assign lkUncond = lkHit && uncondQ[lkIdx];
  assign lkTaken  = lkHit && (uncondQ[lkIdx] || ctrQ[lkIdx][1]);
  assign lkTarget = targetQ[lkIdx];

  assign upHit = validQ[upIdx] && (tagQ[upIdx] == upTag);
  assign upCtr = ctrQ[upIdx];
endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic [PC_W-1:0] resTarget,
  input  logic            predTaken,
  input  logic [PC_W-1:0] predTarget,
  input  logic            upHit,
  input  ctr_t            upCtr,
  output btbStrobe_t      stb,
  output logic            flush,
  output logic [PC_W-1:0] redirectPc
);
  logic            wrongDir;
  logic            wrongTgt;
  logic [PC_W-1:0] seqPc;

  assign seqPc    = resPc + PC_W'(4);
  assign wrongDir = predTaken != resTaken;
  assign wrongTgt = predTaken && resTaken && (predTarget != resTarget);

  assign flush      = resValid && (wrongDir || wrongTgt);
  assign redirectPc = resTaken ? resTarget : seqPc;

  always_comb begin
    stb.wrEn       = resValid && (upHit || resTaken);
    stb.loadTarget = resTaken;
    stb.ctrNext    = upHit ? ctrStep(upCtr, resTaken) : CTR_INIT;
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetchPc,
  output logic            fetchHit,
  output logic            fetchTaken,
  output logic            fetchUncond,
  output logic [PC_W-1:0] fetchTarget,
  output logic [PC_W-1:0] nextPc,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic [PC_W-1:0] resTarget,
  input  logic            resUncond,
  input  logic            predTaken,
  input  logic [PC_W-1:0] predTarget,
  output logic            flush,
  output logic [PC_W-1:0] redirectPc
);
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;

  btbStrobe_t stb;
  logic       upHit;
  ctr_t       upCtr;

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) store_i (
    .clk      (clk),
    .rst      (rst),
    .lkIdx    (fetchPc[TAG_LO-1:IDX_LO]),
    .lkTag    (fetchPc[PC_W-1:TAG_LO]),
    .lkHit    (fetchHit),
    .lkTaken  (fetchTaken),
    .lkUncond (fetchUncond),
    .lkTarget (fetchTarget),
    .upIdx    (resPc[TAG_LO-1:IDX_LO]),
    .upTag    (resPc[PC_W-1:TAG_LO]),
    .upTarget (resTarget),
    .upUncond (resUncond),
    .upHit    (upHit),
    .upCtr    (upCtr),
    .stb      (stb)
  );

  btb_ctrl #(.PC_W(PC_W)) ctrl_i (
    .resValid   (resValid),
    .resPc      (resPc),
    .resTaken   (resTaken),
    .resTarget  (resTarget),
    .predTaken  (predTaken),
    .predTarget (predTarget),
    .upHit      (upHit),
    .upCtr      (upCtr),
    .stb        (stb),
    .flush      (flush),
    .redirectPc (redirectPc)
  );

  assign nextPc = fetchTaken ? fetchTarget : fetchPc + PC_W'(4);
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetchPc,
  input logic            fetchHit,
  input logic            fetchTaken,
  input logic            fetchUncond,
  input logic [PC_W-1:0] fetchTarget,
  input logic [PC_W-1:0] nextPc,
  input logic            resValid,
  input logic [PC_W-1:0] resPc,
  input logic            resTaken,
  input logic [PC_W-1:0] resTarget,
  input logic            resUncond,
  input logic            predTaken,
  input logic [PC_W-1:0] predTarget,
  input logic            flush,
  input logic [PC_W-1:0] redirectPc
);
  // R1
  post_reset_miss_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fetchHit);

  // R2
  miss_sequential_chk: assert property (@(posedge clk) disable iff (rst)
    !fetchHit |-> (!fetchTaken && nextPc == fetchPc + PC_W'(4)));

  // R6
  uncond_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (fetchHit && fetchUncond) |-> (fetchTaken && nextPc == fetchTarget));

  // R7
  late_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && !predTaken && resTaken) |-> (flush && redirectPc == resTarget));

  // R8
  false_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && predTaken && !resTaken) |-> (flush && redirectPc == resPc + PC_W'(4)));

  // R9
  bad_target_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && predTaken && resTaken && predTarget != resTarget) |-> flush);

  // R10
  flush_needs_res_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> resValid);

  // R10
  correct_no_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && predTaken == resTaken && (!resTaken || predTarget == resTarget)) |-> !flush);

  logic unusedOk;
  assign unusedOk = resUncond;
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) chk_i (.*);

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [PC_W-1:0] fetchPc;
  logic            fetchHit, fetchTaken, fetchUncond;
  logic [PC_W-1:0] fetchTarget, nextPc;
  logic            resValid, resTaken, resUncond, predTaken;
  logic [PC_W-1:0] resPc, resTarget, predTarget;
  logic            flush;
  logic [PC_W-1:0] redirectPc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  btb_predictor uut (.*);

  typedef struct packed {
    logic [7:0]  rq;
    logic        rv;
    logic [31:0] rpc;
    logic        rtk;
    logic [31:0] rtg;
    logic        run;
    logic        ptk;
    logic [31:0] ptg;
    logic [31:0] fpc;
    logic        eHit;
    logic        eTk;
    logic        eUnc;
    logic [31:0] eNext;
    logic        eFl;
    logic [31:0] eRd;
  } vec_t;

  // A=0x100 and B=0x140 share index 0; C=0x104 index 1; D=0x208 index 2
  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    // R2: empty table misses
    '{8'd2, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h100, 1'b0, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0},
    // R7: taken miss flushes to target; same-cycle lookup still misses
    '{8'd7, 1'b1, 32'h100, 1'b1, 32'h400, 1'b0, 1'b0, 32'h0, 32'h100, 1'b0, 1'b0, 1'b0, 32'h104, 1'b1, 32'h400},
    // R4: allocated weakly taken
    '{8'd4, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h100, 1'b1, 1'b1, 1'b0, 32'h400, 1'b0, 32'h0},
    // R11: lookup sees old counter while it is decremented (also R8 redirect)
    '{8'd11, 1'b1, 32'h100, 1'b0, 32'h0, 1'b0, 1'b1, 32'h400, 32'h100, 1'b1, 1'b1, 1'b0, 32'h400, 1'b1, 32'h104},
    // R5: counter 1 predicts not-taken
    '{8'd5, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h100, 1'b1, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0},
    // R10: correct not-taken, no flush
    '{8'd10, 1'b1, 32'h100, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h104, 1'b0, 1'b0, 1'b0, 32'h108, 1'b0, 32'h0},
    // R10: correct not-taken at counter 0
    '{8'd10, 1'b1, 32'h100, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h100, 1'b1, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0},
    // R5: counter held at 0 (wrap would predict taken)
    '{8'd5, 1'b1, 32'h100, 1'b1, 32'h400, 1'b0, 1'b0, 32'h0, 32'h100, 1'b1, 1'b0, 1'b0, 32'h104, 1'b1, 32'h400},
    // R7: late taken at counter 1
    '{8'd7, 1'b1, 32'h100, 1'b1, 32'h400, 1'b0, 1'b0, 32'h0, 32'h100, 1'b1, 1'b0, 1'b0, 32'h104, 1'b1, 32'h400},
    // R10: correct taken, counter 2 -> 3
    '{8'd10, 1'b1, 32'h100, 1'b1, 32'h400, 1'b0, 1'b1, 32'h400, 32'h100, 1'b1, 1'b1, 1'b0, 32'h400, 1'b0, 32'h0},
    // R10: correct taken at saturation
    '{8'd10, 1'b1, 32'h100, 1'b1, 32'h400, 1'b0, 1'b1, 32'h400, 32'h100, 1'b1, 1'b1, 1'b0, 32'h400, 1'b0, 32'h0},
    // R5: counter held at 3 (wrap would predict not-taken)
    '{8'd5, 1'b1, 32'h100, 1'b0, 32'h0, 1'b0, 1'b1, 32'h400, 32'h100, 1'b1, 1'b1, 1'b0, 32'h400, 1'b1, 32'h104},
    // R5: counter 2 predicts taken
    '{8'd5, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h100, 1'b1, 1'b1, 1'b0, 32'h400, 1'b0, 32'h0},
    // R9: right direction, wrong target
    '{8'd9, 1'b1, 32'h100, 1'b1, 32'h800, 1'b0, 1'b1, 32'h400, 32'h100, 1'b1, 1'b1, 1'b0, 32'h400, 1'b1, 32'h800},
    // R13: new target stored
    '{8'd13, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h100, 1'b1, 1'b1, 1'b0, 32'h800, 1'b0, 32'h0},
    // R8: predicted taken, resolved not-taken
    '{8'd8, 1'b1, 32'h100, 1'b0, 32'hDEAD0, 1'b0, 1'b1, 32'h800, 32'h100, 1'b1, 1'b1, 1'b0, 32'h800, 1'b1, 32'h104},
    // R13: not-taken kept the target
    '{8'd13, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h100, 1'b1, 1'b1, 1'b0, 32'h800, 1'b0, 32'h0},
    // R4: not-taken miss, no flush
    '{8'd4, 1'b1, 32'h208, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h208, 1'b0, 1'b0, 1'b0, 32'h20C, 1'b0, 32'h0},
    // R4: nothing was allocated
    '{8'd4, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h208, 1'b0, 1'b0, 1'b0, 32'h20C, 1'b0, 32'h0},
    // R3: same index, other tag misses
    '{8'd3, 1'b1, 32'h140, 1'b1, 32'h900, 1'b0, 1'b0, 32'h0, 32'h140, 1'b0, 1'b0, 1'b0, 32'h144, 1'b1, 32'h900},
    // R12: conflicting branch now owns the slot
    '{8'd12, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h140, 1'b1, 1'b1, 1'b0, 32'h900, 1'b0, 32'h0},
    // R12: old branch evicted
    '{8'd12, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h100, 1'b0, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0},
    // R7: unconditional branch allocated
    '{8'd7, 1'b1, 32'h104, 1'b1, 32'h800, 1'b1, 1'b0, 32'h0, 32'h104, 1'b0, 1'b0, 1'b0, 32'h108, 1'b1, 32'h800},
    // R6: unconditional hit, counter 2 drops to 1
    '{8'd6, 1'b1, 32'h104, 1'b0, 32'h0, 1'b1, 1'b1, 32'h800, 32'h104, 1'b1, 1'b1, 1'b1, 32'h800, 1'b1, 32'h108},
    // R6: still taken with counter 1
    '{8'd6, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h104, 1'b1, 1'b1, 1'b1, 32'h800, 1'b0, 32'h0}
  };

  function automatic string reqName(input logic [7:0] n);
    case (n)
      8'd1:  return "R1";
      8'd2:  return "R2";
      8'd3:  return "R3";
      8'd4:  return "R4";
      8'd5:  return "R5";
      8'd6:  return "R6";
      8'd7:  return "R7";
      8'd8:  return "R8";
      8'd9:  return "R9";
      8'd10: return "R10";
      8'd11: return "R11";
      8'd12: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idleRes();
    resValid = 1'b0; resPc = '0; resTaken = 1'b0; resTarget = '0;
    resUncond = 1'b0; predTaken = 1'b0; predTarget = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    rst = 1'b1;
    fetchPc = 32'h104;
    idleRes();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    // R1: reset state
    check("R1", "hit after reset", {31'b0, fetchHit}, 32'h0);
    check("R1", "flush after reset", {31'b0, flush}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      resValid = VEC[i].rv; resPc = VEC[i].rpc; resTaken = VEC[i].rtk;
      resTarget = VEC[i].rtg; resUncond = VEC[i].run;
      predTaken = VEC[i].ptk; predTarget = VEC[i].ptg;
      fetchPc = VEC[i].fpc;
      #2;
      check(reqName(VEC[i].rq), $sformatf("v%0d hit", i), {31'b0, fetchHit}, {31'b0, VEC[i].eHit});
      check(reqName(VEC[i].rq), $sformatf("v%0d taken", i), {31'b0, fetchTaken}, {31'b0, VEC[i].eTk});
      if (VEC[i].eHit)
        check(reqName(VEC[i].rq), $sformatf("v%0d uncond", i), {31'b0, fetchUncond}, {31'b0, VEC[i].eUnc});
      check(reqName(VEC[i].rq), $sformatf("v%0d nextPc", i), nextPc, VEC[i].eNext);
      check(reqName(VEC[i].rq), $sformatf("v%0d flush", i), {31'b0, flush}, {31'b0, VEC[i].eFl});
      if (VEC[i].eFl)
        check(reqName(VEC[i].rq), $sformatf("v%0d redirect", i), redirectPc, VEC[i].eRd);
    end

    // R1: reset in the middle clears trained entries (B at 0x140, C at 0x104)
    @(negedge clk);
    idleRes();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    fetchPc = 32'h140;
    #2;
    check("R1", "B after reset hit", {31'b0, fetchHit}, 32'h0);
    check("R1", "B after reset nextPc", nextPc, 32'h144);
    fetchPc = 32'h104;
    #1;
    check("R1", "C after reset hit", {31'b0, fetchHit}, 32'h0);
    check("R1", "C after reset nextPc", nextPc, 32'h108);

    // R9: same target with both taken is not a flush, a changed one is
    @(negedge clk);
    resValid = 1'b1; resPc = 32'h208; resTaken = 1'b1; resTarget = 32'hA00;
    predTaken = 1'b1; predTarget = 32'hA04;
    #2;
    check("R9", "target mismatch flush", {31'b0, flush}, 32'h1);
    check("R9", "target mismatch redirect", redirectPc, 32'hA00);
    @(negedge clk);
    idleRes();
    fetchPc = 32'h208;
    #2;
    check("R4", "taken miss allocated", nextPc, 32'hA00);

    @(negedge clk);
    finishRun();
  end
endmodule